// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous memory of 32-bit words, split into four 8-bit lanes. Address, chip select, write data and all write controls are captured on a rising clock edge. The array is accessed from those captured values during the following cycle. Read data then passes through an output register, so a read returns one clock later than the array access.

A write covers any set of one to four lanes. Three controls select the lanes. A global write input, when low, writes every lane. Otherwise a master lane enable must be low, and then each lane whose own enable is low is written. A cycle that selects no lane is a read.

The output side has a drive-enable signal in place of a tri-state buffer. It follows the asynchronous output enable with no clock edge in between. It is also forced off for the whole cycle in which a captured write is carried out. The depth is a parameter and is kept small for simulation.

Top module: `pipe_bw_sram`

## Requirements
- R1: After reset, `rdata_o` is zero. With no captured write pending, `drive_o` equals the inverse of `oe_n_i`.
- R2: A read whose inputs are sampled on one rising edge shows the addressed word on `rdata_o` right after the second rising edge.
- R3: With `all_we_n_i` high and `lane_master_n_i` low, lane i is written only if `lane_we_n_i[i]` is low. Lane i is data bits 8i+7 down to 8i. Lanes whose enable is high keep their stored value.
- R4: With `all_we_n_i` low, all four lanes are written, whatever `lane_master_n_i` and `lane_we_n_i` hold.
- R5: With `all_we_n_i` high and `lane_master_n_i` high, the cycle is a read and no lane is written.
- R6: With `all_we_n_i` high, `lane_master_n_i` low and all of `lane_we_n_i` high, the cycle is a read and no lane is written.
- R7: `rdata_o` keeps its value through any cycle that does not carry out a read, including write cycles.
- R8: While `sel_n_i` is high when sampled, nothing is written and `rdata_o` does not change.
- R9: `drive_o` goes low as soon as `oe_n_i` goes high, with no clock edge needed.
- R10: `drive_o` is low during the cycle after a selected write was sampled.
- R11: A read of the same address, sampled on the edge after a write, returns the newly written lanes merged with the lanes it left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | ADDR_W | Word address |
| sel_n_i | input | 1 | Active-low chip select |
| wdata_i | input | 32 | Write data, four 8-bit lanes |
| lane_we_n_i | input | 4 | Active-low per-lane write enables |
| lane_master_n_i | input | 1 | Active-low master enable for the per-lane write enables |
| all_we_n_i | input | 1 | Active-low global write; all lanes |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | High when the data pins would be driven |

## Verification
The assertions assume that every input is settled at the rising clock edge. They also assume that an address is not read before it has been written since power-up, because the array has no reset. The stimulus changes inputs only on the falling edge. It first fills every word with a global write, and only then starts reads and partial-lane writes. It moves `oe_n_i` between edges only in the test that targets the asynchronous enable.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/psram_wr_decode.sv
module psram_wr_decode
  import psram_pkg::*;
(
  input  lane_mask_t lane_we_n_i,
  input  logic       lane_master_n_i,
  input  logic       all_we_n_i,
  output lane_mask_t mask_o
);
  // global write wins over the lane controls
  always_comb begin
    if (!all_we_n_i)           mask_o = '1;
    else if (!lane_master_n_i) mask_o = ~lane_we_n_i;
    else                       mask_o = '0;
  end
endmodule

// File: rtl/psram_in_reg.sv
module psram_in_reg
  import psram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  lane_mask_t        mask_i,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q,
  output lane_mask_t        mask_q
);
  logic              sel_d;
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] wdata_d;
  lane_mask_t        mask_d;

  always_comb begin
    sel_d   = ~sel_n_i;
    addr_d  = addr_i;
    wdata_d = wdata_i;
    mask_d  = mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      sel_q   <= sel_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lane_mask_t        we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rword_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rword_o[g*LANE_W +: LANE_W] = mem[addr_i];

    // R3
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_i[g]) |-> mem[$past(addr_i)] == $past(wdata_i[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/psram_out_reg.sv
module psram_out_reg
  import psram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] dout_o
);
  logic [WORD_W-1:0] dout_d;

  always_comb dout_d = load_i ? din_i : dout_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_o <= '0;
    else        dout_o <= dout_d;
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(dout_o));
endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        lane_we_n_i,
  input  logic              lane_master_n_i,
  input  logic              all_we_n_i,
  input  logic              oe_n_i,
  output logic [31:0]       rdata_o,
  output logic              drive_o
);
  logic [1:0]        rst_sync;
  logic              rst_n_int;
  lane_mask_t        mask_d, mask_q, we;
  logic              sel_q, wr_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  psram_wr_decode u_dec (
    .lane_we_n_i     (lane_we_n_i),
    .lane_master_n_i (lane_master_n_i),
    .all_we_n_i      (all_we_n_i),
    .mask_o          (mask_d)
  );

  psram_in_reg #(.ADDR_W(ADDR_W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sel_n_i (sel_n_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mask_i  (mask_d),
    .sel_q   (sel_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .mask_q  (mask_q)
  );

  always_comb begin
    we   = sel_q ? mask_q : '0;
    wr_q = |we;
    rd_q = sel_q & ~(|mask_q);
  end

  psram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (we),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .rword_o (rword)
  );

  psram_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (rd_q),
    .din_i  (rword),
    .dout_o (rdata_o)
  );

  // output drive is combinational on oe_n_i
  assign drive_o = ~oe_n_i & ~wr_q;

  // R4
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sel_n_i && !all_we_n_i) |=> (mask_q == '1 && sel_q));

  // R10
  drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sel_n_i && (!all_we_n_i || (!lane_master_n_i && !(&lane_we_n_i)))) |=> !drive_o);

  // R8
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    sel_n_i |=> ##1 $stable(rdata_o));
endmodule

// File: tb/pipe_bw_sram_bench.sv
module pipe_bw_sram_bench;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_n;
  logic [31:0]   wdata;
  logic [3:0]    lane_n;
  logic          master_n;
  logic          glob_n;
  logic          oe_n;
  logic [31:0]   rdata;
  logic          drive;

  int checks = 0;
  int fails  = 0;

  logic [31:0]   ref_mem [DEPTH];
  logic [31:0]   exp_q;
  logic          p_rd, p_wr;
  logic [3:0]    p_mask;
  logic [AW-1:0] p_addr;
  logic [31:0]   p_data;

  always #5 clk = ~clk;

  pipe_bw_sram #(.ADDR_W(AW)) u_pipe_bw_sram (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_n_i(sel_n), .wdata_i(wdata),
    .lane_we_n_i(lane_n), .lane_master_n_i(master_n), .all_we_n_i(glob_n),
    .oe_n_i(oe_n), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: drive_o=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_of(logic [3:0] ln, logic mn, logic gn);
    if (!gn)      return 4'hF;
    else if (!mn) return ~ln;
    else          return 4'h0;
  endfunction

  task automatic step(string tag, logic s_n, logic [AW-1:0] a, logic [31:0] d,
                      logic [3:0] ln, logic mn, logic gn);
    logic [3:0] m;
    @(negedge clk);
    sel_n = s_n; addr = a; wdata = d; lane_n = ln; master_n = mn; glob_n = gn;
    @(posedge clk);
    if (p_wr) begin
      for (int i = 0; i < 4; i++)
        if (p_mask[i]) ref_mem[p_addr][i*8 +: 8] = p_data[i*8 +: 8];
    end else if (p_rd) begin
      exp_q = ref_mem[p_addr];
    end
    m      = lanes_of(ln, mn, gn);
    p_wr   = !s_n && (m != 4'h0);
    p_rd   = !s_n && (m == 4'h0);
    p_mask = m;
    p_addr = a;
    p_data = d;
    #2;
    chk32(tag, rdata, exp_q);
    chk1(tag, drive, !oe_n && !p_wr);
  endtask

  function automatic logic [31:0] pat(int k);
    return 32'h9E37_79B9 * (k + 1) ^ 32'h5A5A_0000;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; addr = '0; wdata = '0; lane_n = 4'hF;
    master_n = 1'b1; glob_n = 1'b1; oe_n = 1'b0;
    p_rd = 1'b0; p_wr = 1'b0; p_mask = '0; p_addr = '0; p_data = '0; exp_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk32("R1", rdata, 32'h0);
    chk1("R1", drive, 1'b1);

    // R4 fill every word with a global write, lane controls varied
    for (int a = 0; a < DEPTH; a++)
      step("R4", 1'b0, a[AW-1:0], pat(a), a[3:0], a[0], 1'b0);
    // R2 back-to-back reads of every word
    for (int a = 0; a < DEPTH; a++)
      step("R2", 1'b0, a[AW-1:0], 32'h0, 4'hF, 1'b1, 1'b1);
    step("R2", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);

    // R3 R5 R6 R11 every lane pattern with master on and off, then read
    for (int mm = 0; mm < 2; mm++)
      for (int ln = 0; ln < 16; ln++) begin
        if (mm == 1)       step("R5", 1'b0, 4'd5, pat(ln + 40), ln[3:0], 1'b1, 1'b1);
        else if (ln == 15) step("R6", 1'b0, 4'd5, pat(ln + 40), ln[3:0], 1'b0, 1'b1);
        else               step("R3", 1'b0, 4'd5, pat(ln + 40), ln[3:0], 1'b0, 1'b1);
        step("R11", 1'b0, 4'd5, 32'h0, 4'hF, 1'b1, 1'b1);
      end
    step("R11", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);

    // R7 read then a run of writes: output holds
    step("R7", 1'b0, 4'd2, 32'h0, 4'hF, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++)
      step("R7", 1'b0, 4'd9, pat(k + 90), 4'h0, 1'b0, 1'b1);
    // R10 global write with output enabled: drive off next cycle
    step("R10", 1'b0, 4'd9, pat(77), 4'hF, 1'b1, 1'b0);
    step("R10", 1'b0, 4'd9, 32'h0, 4'hF, 1'b1, 1'b1);
    step("R10", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);

    // R8 deselected writes and reads change nothing
    step("R8", 1'b0, 4'd3, 32'h0, 4'hF, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++)
      step("R8", 1'b1, 4'd3, 32'hDEAD_0000 + k, 4'h0, 1'b0, 1'b0);
    step("R8", 1'b0, 4'd3, 32'h0, 4'hF, 1'b1, 1'b1);
    step("R8", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);
    step("R8", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);

    // R9 output enable acts between edges
    @(negedge clk);
    #1 oe_n = 1'b1;
    #1 chk1("R9", drive, 1'b0);
    #1 oe_n = 1'b0;
    #1 chk1("R9", drive, 1'b1);
    step("R9", 1'b0, 4'd4, 32'h0, 4'hF, 1'b1, 1'b1);
    @(negedge clk) oe_n = 1'b1;
    #1 chk1("R9", drive, 1'b0);
    chk32("R9", rdata, exp_q);
    @(negedge clk) oe_n = 1'b0;
    step("R9", 1'b1, '0, 32'h0, 4'hF, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule